// File: doc/BRIEF.md
# Multi-Mode Waveform Timer/Counter

An 8-bit (parameterised) timer/counter that advances on a count-enable tick and is configured by a 3-bit mode code. The mode selects how the counter moves (up and wrap, up and clear at a ceiling, or up then down), what value is the ceiling (all ones or compare register A), when new compare values take effect, and on which count the overflow flag is raised. Two compare channels, A and B, compare against the counter. Each produces a one-cycle match strobe and drives a waveform output according to a 2-bit action field.

Software-side writes arrive through one write port that selects the counter, either compare register or the control register. The overflow flag is sticky until acknowledged. The reset input is asynchronous and active-low, and its release is synchronised inside the block, which takes two clock edges.

Top module: `timer8_multi`

## Requirements
- R1: After reset, count is 0, the control register is 0 (mode 0, both actions 00), both compare registers are 0, and ovf_flag, cmpa_hit, cmpb_hit, wave_a and wave_b are all 0.
- R2: A write with wr_en=1 takes effect at the clock edge. wr_sel 0 loads the counter, 1 loads compare A, 2 loads compare B, and 3 loads control. Control bits [2:0] are the mode, bits [4:3] are the action for channel A, and bits [6:5] are the action for channel B. A counter write overrides any tick in the same cycle.
- R3: Mode 0 counts up by one per tick and wraps from 0xFF to 0x00. ovf_flag is set at the same edge at which the counter becomes 0.
- R4: ovf_flag is set only by hardware and cleared only by ovf_ack=1. If a set and an acknowledge fall in the same cycle, the set wins.
- R5: In mode 2 the counter counts up to the value of compare A and clears to 0 on the next tick. ovf_flag is set only on a tick taken at 0xFF.
- R6: Modes 3 and 7 count up and return to 0 on the tick taken at the ceiling, which is 0xFF for mode 3 and compare A for mode 7. ovf_flag is set on the tick taken at 0xFF in mode 3 and at the ceiling in mode 7.
- R7: Modes 1 and 5 count up to the ceiling (0xFF for mode 1, compare A for mode 5) and then down to 0, and repeat. ovf_flag is set on each tick taken at 0.
- R8: In modes 0, 2, 4 and 6 compare writes act at once. In modes 1, 3 and 5 they act on the tick taken at the ceiling. In mode 7 they act on the tick taken at 0.
- R9: cmpa_hit (or cmpb_hit) is 1 for the one cycle after a tick taken while the counter equals the active compare value. This strobe is suppressed on the first tick after a counter write.
- R10: In modes 0 and 2, a match applies the channel action to its wave output: 00 none, 01 toggle, 10 clear, 11 set.
- R11: In modes 3 and 7, action 10 clears the wave on a match and sets it on the tick taken at the ceiling. Action 11 does the opposite. The ceiling event wins over a match, and actions 0x leave the wave unchanged.
- R12: In modes 1 and 5, action 10 clears the wave on a match while counting up and sets it on a match while counting down. Action 11 does the opposite.
- R13: Mode codes 4 and 6 hold the counter, raise no overflow and no compare strobes, and leave both wave outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable for one step |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 compare A, 2 compare B, 3 control |
| wr_data | input | W | Write data |
| ovf_ack | input | 1 | Clears the overflow flag |
| count | output | W | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmpa_hit | output | 1 | Channel A match strobe |
| cmpb_hit | output | 1 | Channel B match strobe |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |

## Verification
Every output comes from a register. A tick, write or acknowledge that is sampled at a rising edge therefore shows on count, ovf_flag, the strobes and the waves right after that same edge, and the match strobes are always exactly one edge behind the tick that caused them. The bench drives inputs on falling edges and advances its behavioural model at each rising edge using those inputs. It then compares all outputs at the following falling edge, so every result is checked in the cycle it is due. The compare buffering points and the write-suppressed match are checked by the same per-cycle comparison, across mode switches made mid-count.

// File: rtl/timer8_pkg.sv
package timer8_pkg;

  localparam int MODE_W = 3;
  localparam int ACT_W  = 2;
  localparam int CTRL_W = MODE_W + 2 * ACT_W;

  localparam logic [1:0] SEL_CNT  = 2'd0;
  localparam logic [1:0] SEL_CMPA = 2'd1;
  localparam logic [1:0] SEL_CMPB = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  localparam logic [ACT_W-1:0] ACT_TGL = 2'b01;
  localparam logic [ACT_W-1:0] ACT_CLR = 2'b10;
  localparam logic [ACT_W-1:0] ACT_SET = 2'b11;

  typedef enum logic [1:0] {
    OVF_NONE   = 2'd0,
    OVF_MAX    = 2'd1,
    OVF_BOTTOM = 2'd2,
    OVF_TOP    = 2'd3
  } ovf_src_e;

  typedef struct packed {
    logic     hold;
    logic     top_a;
    logic     phase;
    logic     fast;
    logic     buffered;
    logic     upd_bottom;
    ovf_src_e ovf_at;
  } mode_cfg_t;

endpackage

// File: rtl/tmr_mode_decode.sv
module tmr_mode_decode
  import timer8_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output mode_cfg_t         cfg
);

  always_comb begin
    cfg = '{hold: 1'b0, top_a: 1'b0, phase: 1'b0, fast: 1'b0,
            buffered: 1'b0, upd_bottom: 1'b0, ovf_at: OVF_MAX};
    case (mode)
      3'd0: ;
      3'd1: begin cfg.phase = 1'b1; cfg.buffered = 1'b1; cfg.ovf_at = OVF_BOTTOM; end
      3'd2: cfg.top_a = 1'b1;
      3'd3: begin cfg.fast = 1'b1; cfg.buffered = 1'b1; end
      3'd5: begin
        cfg.phase = 1'b1; cfg.top_a = 1'b1; cfg.buffered = 1'b1; cfg.ovf_at = OVF_BOTTOM;
      end
      3'd7: begin
        cfg.fast = 1'b1; cfg.top_a = 1'b1; cfg.buffered = 1'b1;
        cfg.upd_bottom = 1'b1; cfg.ovf_at = OVF_TOP;
      end
      default: begin cfg.hold = 1'b1; cfg.ovf_at = OVF_NONE; end
    endcase
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         phase,
  input  logic         clr_at_top,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] cnt,
  output logic         dir_down
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         dir_q, dir_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = phase ? dir_q : 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (step && !hold) begin
      if (phase) begin
        if (top_val == '0) begin
          cnt_d = '0;
        end else if (!dir_q) begin
          if (cnt_q == top_val) begin
            cnt_d = cnt_q - 1'b1;
            dir_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else if (cnt_q == '0) begin
          cnt_d = {{(W-1){1'b0}}, 1'b1};
          dir_d = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else if (clr_at_top && cnt_q == top_val) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt      = cnt_q;
  assign dir_down = dir_q;

  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load) |=> $stable(cnt_q)); // R13
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val))); // R2
  AST_PHASE_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase && step && !hold && !load && !dir_q && cnt_q == top_val && top_val != '0)
      |=> dir_q); // R7

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
  import timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             fast,
  input  logic             phase,
  input  logic             buffered,
  input  logic             wr,
  input  logic [W-1:0]     wr_val,
  input  logic             upd,
  input  logic             match_en,
  input  logic             wrap,
  input  logic             dir_down,
  input  logic [W-1:0]     cnt,
  input  logic [ACT_W-1:0] act,
  output logic [W-1:0]     act_val,
  output logic             hit,
  output logic             wave
);

  logic [W-1:0] sh_q, sh_d, act_q, act_d;
  logic         hit_q, wave_q, wave_d, match;

  assign match = match_en && (cnt == act_q);

  always_comb begin
    sh_d  = wr ? wr_val : sh_q;
    act_d = act_q;
    if (!buffered)  act_d = sh_d;
    else if (upd)   act_d = sh_q;
  end

  always_comb begin
    wave_d = wave_q;
    if (!hold) begin
      if (fast) begin
        if (act[1]) begin
          if (wrap)       wave_d = ~act[0];
          else if (match) wave_d = act[0];
        end
      end else if (phase) begin
        if (act[1] && match) wave_d = dir_down ? ~act[0] : act[0];
      end else if (match) begin
        case (act)
          ACT_TGL: wave_d = ~wave_q;
          ACT_CLR: wave_d = 1'b0;
          ACT_SET: wave_d = 1'b1;
          default: wave_d = wave_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      act_q  <= '0;
      hit_q  <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      act_q  <= act_d;
      hit_q  <= match;
      wave_q <= wave_d;
    end
  end

  assign act_val = act_q;
  assign hit     = hit_q;
  assign wave    = wave_q;

  AST_BUFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (buffered && !upd) |=> $stable(act_q)); // R8
  AST_RESERVED_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(wave_q)); // R13

endmodule

// File: rtl/timer8_multi.sv
module timer8_multi
  import timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         ovf_ack,
  output logic [W-1:0] count,
  output logic         ovf_flag,
  output logic         cmpa_hit,
  output logic         cmpb_hit,
  output logic         wave_a,
  output logic         wave_b
);

  localparam int           NCH     = 2;
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [1:0]        rst_sync;
  logic              srst_n;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ovf_q, ovf_d, blk_q, blk_d;
  logic              cnt_wr, step, at_top, at_bot, upd, match_en, wrap, ovf_hit;
  logic              dir_down;
  logic [W-1:0]      cnt, top_val;
  mode_cfg_t         cfg;
  logic [NCH-1:0]    ch_wr, ch_hit, ch_wave;
  logic [W-1:0]      ch_act [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  tmr_mode_decode u_dec (.mode(ctrl_q[MODE_W-1:0]), .cfg(cfg));

  assign cnt_wr   = wr_en && (wr_sel == SEL_CNT);
  assign step     = tick && !cnt_wr;
  assign top_val  = cfg.top_a ? ch_act[0] : CNT_MAX;
  assign at_top   = (cnt == top_val);
  assign at_bot   = (cnt == '0);
  assign upd      = step && cfg.buffered && (cfg.upd_bottom ? at_bot : at_top);
  assign match_en = step && !blk_q && !cfg.hold;
  assign wrap     = step && cfg.fast && at_top;
  assign ch_wr[0] = wr_en && (wr_sel == SEL_CMPA);
  assign ch_wr[1] = wr_en && (wr_sel == SEL_CMPB);

  always_comb begin
    case (cfg.ovf_at)
      OVF_MAX:    ovf_hit = step && (cnt == CNT_MAX);
      OVF_BOTTOM: ovf_hit = step && at_bot;
      OVF_TOP:    ovf_hit = step && at_top;
      default:    ovf_hit = 1'b0;
    endcase
    ovf_d  = ovf_hit ? 1'b1 : (ovf_ack ? 1'b0 : ovf_q);
    blk_d  = cnt_wr ? 1'b1 : (tick ? 1'b0 : blk_q);
    ctrl_d = (wr_en && wr_sel == SEL_CTRL) ? wr_data[CTRL_W-1:0] : ctrl_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ovf_q  <= ovf_d;
      blk_q  <= blk_d;
    end
  end

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(srst_n), .hold(cfg.hold), .phase(cfg.phase),
    .clr_at_top(cfg.top_a || cfg.fast), .step(step), .load(cnt_wr),
    .load_val(wr_data), .top_val(top_val), .cnt(cnt), .dir_down(dir_down)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_cmp_chan #(.W(W)) u_ch (
      .clk(clk), .rst_n(srst_n), .hold(cfg.hold), .fast(cfg.fast),
      .phase(cfg.phase), .buffered(cfg.buffered), .wr(ch_wr[i]),
      .wr_val(wr_data), .upd(upd), .match_en(match_en), .wrap(wrap),
      .dir_down(dir_down), .cnt(cnt),
      .act(ctrl_q[MODE_W + ACT_W*i +: ACT_W]),
      .act_val(ch_act[i]), .hit(ch_hit[i]), .wave(ch_wave[i])
    );
  end

  assign count    = cnt;
  assign ovf_flag = ovf_q;
  assign cmpa_hit = ch_hit[0];
  assign cmpb_hit = ch_hit[1];
  assign wave_a   = ch_wave[0];
  assign wave_b   = ch_wave[1];

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!srst_n)
    (ovf_q && !ovf_ack) |=> ovf_q); // R4
  AST_NORMAL_WRAP: assert property (@(posedge clk) disable iff (!srst_n)
    (ctrl_q[MODE_W-1:0] == 3'd0 && step && cnt == CNT_MAX) |=> (count == '0 && ovf_flag)); // R3
  AST_CTC_CLEAR: assert property (@(posedge clk) disable iff (!srst_n)
    (ctrl_q[MODE_W-1:0] == 3'd2 && step && cnt == ch_act[0]) |=> (count == '0)); // R5
  AST_WRITE_MASK: assert property (@(posedge clk) disable iff (!srst_n)
    (blk_q && tick) |=> (!cmpa_hit && !cmpb_hit)); // R9
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    (cfg.hold && !ovf_q) |=> (!ovf_flag && !cmpa_hit && !cmpb_hit)); // R13

endmodule

// File: tb/tb_timer8_multi.sv
module tb_timer8_multi;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         ovf_ack = 1'b0;
  logic [W-1:0] count;
  logic         ovf_flag, cmpa_hit, cmpb_hit, wave_a, wave_b;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur     = "R1";

  // behavioural reference state
  int m_cnt, m_sha, m_shb, m_acta, m_actb, m_ctrl;
  bit m_dir, m_ovf, m_hita, m_hitb, m_wa, m_wb, m_blk;

  timer8_multi #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ovf_ack(ovf_ack), .count(count), .ovf_flag(ovf_flag),
    .cmpa_hit(cmpa_hit), .cmpb_hit(cmpb_hit), .wave_a(wave_a), .wave_b(wave_b)
  );

  always #10 clk = ~clk;

  function automatic bit new_wave(bit w, int act, bit match, bit wrp, bit down,
                                  int mode);
    if (mode == 3 || mode == 7) begin
      if (act >= 2 && wrp)   return act == 2;
      if (act >= 2 && match) return act == 3;
      return w;
    end
    if (mode == 1 || mode == 5) begin
      if (act >= 2 && match) return (act == 2) ? down : !down;
      return w;
    end
    if (mode == 4 || mode == 6 || !match) return w;
    if (act == 1) return !w;
    if (act == 2) return 0;
    if (act == 3) return 1;
    return w;
  endfunction

  task automatic model_edge();
    int  mode = m_ctrl % 8;
    bit  res  = (mode == 4 || mode == 6);
    bit  ph   = (mode == 1 || mode == 5);
    bit  fst  = (mode == 3 || mode == 7);
    bit  buff = (mode == 1 || mode == 3 || mode == 5 || mode == 7);
    int  top  = (mode == 2 || mode == 5 || mode == 7) ? m_acta : 255;
    bit  cw   = wr_en && wr_sel == 0;
    bit  stp  = tick && !cw;
    bit  ma, mb, wrp, ovh, upd, nd;
    int  nc, nsa, nsb;
    nc = m_cnt; nd = ph ? m_dir : 0;
    if (cw) nc = wr_data;
    else if (stp && !res) begin
      if (ph) begin
        if (top == 0) nc = 0;
        else if (!m_dir) begin
          if (m_cnt == top) begin nc = m_cnt - 1; nd = 1; end
          else nc = (m_cnt + 1) % 256;
        end else if (m_cnt == 0) begin nc = 1; nd = 0; end
        else nc = m_cnt - 1;
      end else if ((mode != 0) && m_cnt == top) nc = 0;
      else nc = (m_cnt + 1) % 256;
    end
    ovh = 0;
    if (stp && !res) begin
      if (mode == 1 || mode == 5) ovh = (m_cnt == 0);
      else if (mode == 7)         ovh = (m_cnt == top);
      else                        ovh = (m_cnt == 255);
    end
    ma  = stp && !m_blk && !res && m_cnt == m_acta;
    mb  = stp && !m_blk && !res && m_cnt == m_actb;
    wrp = stp && fst && m_cnt == top;
    upd = stp && buff && ((mode == 7) ? m_cnt == 0 : m_cnt == top);
    m_wa = new_wave(m_wa, (m_ctrl / 8) % 4, ma, wrp, m_dir, mode);
    m_wb = new_wave(m_wb, (m_ctrl / 32) % 4, mb, wrp, m_dir, mode);
    nsa = (wr_en && wr_sel == 1) ? int'(wr_data) : m_sha;
    nsb = (wr_en && wr_sel == 2) ? int'(wr_data) : m_shb;
    if (!buff) begin m_acta = nsa; m_actb = nsb; end
    else if (upd) begin m_acta = m_sha; m_actb = m_shb; end
    m_sha = nsa; m_shb = nsb;
    m_hita = ma; m_hitb = mb;
    m_ovf = ovh ? 1 : (ovf_ack ? 0 : m_ovf);
    m_blk = cw ? 1 : (tick ? 0 : m_blk);
    if (wr_en && wr_sel == 3) m_ctrl = wr_data % 128;
    m_cnt = nc; m_dir = nd;
  endtask

  task automatic compare();
    logic [12:0] act, exp;
    act = {count, ovf_flag, cmpa_hit, cmpb_hit, wave_a, wave_b};
    exp = {m_cnt[7:0], m_ovf, m_hita, m_hitb, m_wa, m_wb};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t cnt/ovf/ha/hb/wa/wb actual=%h_%b%b%b%b%b expected=%h_%b%b%b%b%b",
               cur, $time, act[12:5], act[4], act[3], act[2], act[1], act[0],
               exp[12:5], exp[4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  // one clock: inputs already applied; model at rising edge, check at falling edge
  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    wr_en = 0; ovf_ack = 0;
  endtask

  task automatic wr(input int sel, input int data, input bit tk);
    wr_en = 1; wr_sel = sel[1:0]; wr_data = data[7:0]; tick = tk;
    cyc();
    tick = 0;
  endtask

  task automatic run(input int n, input int tick_pct, input int ack_every);
    for (int i = 0; i < n; i++) begin
      tick = ($urandom_range(0, 99) < tick_pct);
      ovf_ack = (ack_every > 0) && (i % ack_every == ack_every - 1);
      cyc();
    end
    tick = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired in %s", cur);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_cnt = 0; m_sha = 0; m_shb = 0; m_acta = 0; m_actb = 0; m_ctrl = 0;
    m_dir = 0; m_ovf = 0; m_hita = 0; m_hitb = 0; m_wa = 0; m_wb = 0; m_blk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cur = "R1"; compare();
    cyc();

    cur = "R3"; run(300, 100, 0);             // full wrap, flag from 0xFF->0x00
    wr(0, 8'hFD, 0); run(5, 100, 0);
    cur = "R4"; ovf_ack = 1; cyc(); run(20, 100, 0);
    wr(0, 8'hFF, 0); tick = 1; ovf_ack = 1; cyc(); tick = 0; // set beats ack
    run(600, 60, 97);

    cur = "R2"; wr(0, 8'h40, 1); run(4, 100, 0);
    wr(3, 8'h00, 1); wr(1, 8'h10, 0); wr(2, 8'h12, 0);

    cur = "R9"; wr(0, 8'h0E, 0); run(8, 100, 0);
    wr(0, 8'h10, 0); run(6, 100, 0);          // first tick after write masked
    wr(0, 8'h12, 1); run(6, 100, 0);

    cur = "R10"; wr(3, 8'b0_10_01_000, 0); run(700, 80, 0);
    wr(3, 8'b0_11_10_000, 0); run(600, 80, 0);
    wr(3, 8'b0_00_11_000, 0); run(300, 100, 0);

    cur = "R5"; wr(1, 20, 0); wr(2, 7, 0); wr(3, 8'b0_01_01_010, 0);
    run(200, 100, 0); wr(0, 8'hF0, 0); run(40, 100, 0);

    cur = "R6"; wr(2, 8'h40, 0); wr(3, 8'b0_10_11_011, 0); run(700, 100, 50);
    cur = "R11"; wr(1, 50, 0); wr(2, 20, 0); wr(3, 8'b0_10_11_111, 0); run(400, 90, 30);
    wr(2, 50, 0); run(200, 100, 0);           // match at ceiling: ceiling wins
    cur = "R8"; wr(2, 5, 1); run(30, 100, 0); wr(1, 70, 0); run(200, 100, 0);
    wr(3, 8'b0_10_10_011, 0); wr(2, 8'h80, 0); run(10, 100, 0);
    wr(2, 8'h20, 0); run(600, 100, 0);

    cur = "R7"; wr(1, 8'h30, 0); wr(2, 8'h60, 0); wr(3, 8'b0_10_10_001, 0);
    run(1100, 100, 64);
    cur = "R12"; wr(1, 40, 0); wr(2, 15, 0); wr(3, 8'b0_11_10_101, 0);
    run(900, 85, 40);

    cur = "R13"; wr(3, 8'b0_01_01_100, 0); run(50, 100, 0);
    wr(0, 8'h22, 0); run(30, 100, 0);
    wr(3, 8'b0_11_11_110, 0); run(50, 100, 0);

    cur = "R2"; wr(3, 8'b0_01_10_000, 0); run(2000, 50, 120);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule